// File: doc/BRIEF.md
# T1/E1 System-Side Frame Timing Generator

This block produces all system-side timing for the serial output of a T1/E1 elastic store. It runs on the system clock and holds a bit position counter over either a 193-bit T1 frame (one framing bit followed by 24 eight-bit channels) or a 256-bit E1 frame (32 eight-bit channels). From that position it derives the channel and bit indices, a channel clock and a multiframe marker. From a second, optionally advanced position it derives the read address and bit select into the frame buffer and forms the serial output bit.

A rising edge on the frame-sync input pulls the counter back to the start of a frame. Between edges the counter runs freely, so one pulse is enough to establish alignment. For a parallel backplane the data read lags the timing outputs by nothing: it leads them by a fixed look-ahead, so an external shift register has a whole byte when the channel starts. On a T1 system side, the framing bit is either the received framing bit or a forced one, depending on the receive rate. Receive channels beyond the 24th are never addressed. A slip reported by the buffer shifts the multiframe count by one frame, so the multiframe marker stays aligned with the data that was actually sent.

Top module: `sys_frame_timer`

## Requirements
- R1: After reset the position is the first slot of a frame: `chan_idx`=0, `bit_idx`=0, `mf_pulse`=0, and `fbit_slot`=1 when `sys_e1`=0.
- R2: With `sys_e1`=0 the frame is 193 positions long and position 0 is the framing slot. With `sys_e1`=1 it is 256 positions long with no framing slot. Position p of a channel slot maps to channel (p-1)/8 (T1) or p/8 (E1) and bit (p-1)%8 or p%8. The counter wraps to position 0 by itself.
- R3: A rising edge on `fsync`, seen at a clock edge, makes the next cycle position 0. This holds at any point in the frame, and later frames follow without further pulses.
- R4: In serial mode (`par_mode`=0), `rd_addr` and `rd_bit` give the channel and bit of the current position. `ser_out` equals `rd_byte[7-rd_bit]`, so data is sent most significant bit first.
- R5: In parallel mode (`par_mode`=1), `rd_addr`, `rd_bit`, `rd_en` and `ser_out` describe the position 8 ahead (modulo the frame length). `chan_idx`, `bit_idx`, `fbit_slot` and `chan_clk` stay on the current position.
- R6: `chan_clk` is 1 during bits 0 to 3 of each channel and 0 during bits 4 to 7 and in the framing slot, so it rises at every channel boundary.
- R7: With `sys_e1`=0 and `rx_e1`=0, the serial output in the framing slot equals `rx_fbit`.
- R8: With `sys_e1`=0 and `rx_e1`=1, the serial output in the framing slot is 1 regardless of `rx_fbit`.
- R9: With `sys_e1`=0, `rd_addr` never exceeds 23 while `rd_en`=1, so buffer channels 24 to 31 are dropped.
- R10: `mf_pulse` goes high for exactly 65 cycles starting at position 0 of each multiframe. A multiframe is 12 frames long, and a new one starts on every `fsync` rising edge.
- R11: A pulse on `slip_rep` during a frame makes the next multiframe start one frame later. A pulse on `slip_del` makes it start one frame earlier. The adjustment takes effect at the end of that frame.
- R12: `rd_en` is 0 only when the read position is the T1 framing slot, and `fbit_slot` is never 1 when `sys_e1`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_e1 | input | 1 | System rate: 0 = 193-bit T1 frame, 1 = 256-bit E1 frame |
| rx_e1 | input | 1 | Receive rate: 0 = T1, 1 = E1 |
| par_mode | input | 1 | 1 = parallel backplane look-ahead, 0 = serial |
| fsync | input | 1 | System frame sync, rising edge aligns the frame |
| slip_rep | input | 1 | Buffer repeated a frame in this frame |
| slip_del | input | 1 | Buffer deleted a frame in this frame |
| rx_fbit | input | 1 | Framing bit taken from the receive stream |
| rd_byte | input | 8 | Buffer byte at `rd_addr` |
| rd_addr | output | 5 | Channel of the buffer byte being read |
| rd_bit | output | 3 | Bit within the byte, 0 = first sent |
| rd_en | output | 1 | Read position is a channel slot |
| ser_out | output | 1 | Serial system-side data |
| chan_idx | output | 5 | Channel of the current position |
| bit_idx | output | 3 | Bit of the current position |
| fbit_slot | output | 1 | Current position is the T1 framing slot |
| chan_clk | output | 1 | Channel clock |
| mf_pulse | output | 1 | Multiframe marker, 65 cycles wide |

## Verification
The hardest state to reach is a multiframe boundary moved by a slip. It only shows up about 2300 cycles after the slip pulse, and only relative to a known frame-sync reference. Each slip scenario therefore starts with a fresh sync pulse and fires a single-cycle slip pulse early in frame 0. It then samples `mf_pulse` on both sides of the nominal and the shifted boundary. The look-ahead wrap is also awkward to reach: in the last eight positions of a T1 frame, the read position has already crossed into the next framing slot. A full-frame sweep in parallel mode covers that case.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;
    localparam int BYTE_BITS = 8;
    localparam int T1_CHANS  = 24;
    localparam int E1_CHANS  = 32;
    localparam int T1_FRAME  = T1_CHANS * BYTE_BITS + 1;
    localparam int E1_FRAME  = E1_CHANS * BYTE_BITS;
    localparam int POS_W     = $clog2(E1_FRAME);
    localparam int CH_W      = $clog2(E1_CHANS);
    localparam int BIT_W     = $clog2(BYTE_BITS);

    typedef struct packed {
        logic             fslot;
        logic [CH_W-1:0]  chan;
        logic [BIT_W-1:0] bitn;
    } slot_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2
    } mf_step_e;
endpackage

// File: rtl/sft_slot_decode.sv
`timescale 1ns/1ps
module sft_slot_decode
    import sft_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic             sys_e1,
    output slot_t            slot
);
    logic [POS_W-1:0] ofs;

    always_comb begin
        slot = '0;
        ofs  = pos - POS_W'(1);
        if (sys_e1) begin
            slot.chan = pos[BIT_W +: CH_W];
            slot.bitn = pos[BIT_W-1:0];
        end else if (pos == '0 || pos > POS_W'(T1_FRAME - 1)) begin
            // framing slot; positions beyond a T1 frame (left over after a
            // rate change) are treated the same way until the wrap
            slot.fslot = 1'b1;
        end else begin
            slot.chan = ofs[BIT_W +: CH_W];
            slot.bitn = ofs[BIT_W-1:0];
        end
    end
endmodule

// File: rtl/sft_mf_ctrl.sv
`timescale 1ns/1ps
module sft_mf_ctrl
    import sft_pkg::*;
#(
    parameter int MF_FRAMES = 12,
    parameter int MF_HOLD   = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync,
    input  logic frame_end,
    input  logic slip_rep,
    input  logic slip_del,
    output logic mf_pulse
);
    localparam int MF_W   = $clog2(MF_FRAMES + 1);
    localparam int HOLD_W = $clog2(MF_HOLD + 1);

    typedef struct packed {
        logic [MF_W-1:0]   mf;
        logic              rep_p;
        logic              del_p;
        logic [HOLD_W-1:0] hold;
    } mf_st_t;

    mf_st_t   q, d;
    mf_step_e step;
    logic [MF_W:0] sum;

    always_comb begin
        d    = q;
        step = STEP_ONE;
        sum  = '0;
        if (q.hold != '0) d.hold = q.hold - HOLD_W'(1);
        d.rep_p = q.rep_p | slip_rep;
        d.del_p = q.del_p | slip_del;
        if (resync) begin
            d.mf    = '0;
            d.rep_p = 1'b0;
            d.del_p = 1'b0;
            d.hold  = HOLD_W'(MF_HOLD);
        end else if (frame_end) begin
            if (q.rep_p && !q.del_p)      step = STEP_HOLD;
            else if (q.del_p && !q.rep_p) step = STEP_TWO;
            sum = {1'b0, q.mf} + (MF_W+1)'(step);
            if (sum >= (MF_W+1)'(MF_FRAMES)) begin
                d.mf   = MF_W'(sum - (MF_W+1)'(MF_FRAMES));
                d.hold = HOLD_W'(MF_HOLD);
            end else begin
                d.mf = MF_W'(sum);
            end
            d.rep_p = slip_rep;
            d.del_p = slip_del;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mf_pulse = (q.hold != '0);
endmodule

// File: rtl/sys_frame_timer.sv
`timescale 1ns/1ps
module sys_frame_timer
    import sft_pkg::*;
#(
    parameter int MF_FRAMES = 12,
    parameter int MF_HOLD   = 65,
    parameter int LOOKAHEAD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_e1,
    input  logic             rx_e1,
    input  logic             par_mode,
    input  logic             fsync,
    input  logic             slip_rep,
    input  logic             slip_del,
    input  logic             rx_fbit,
    input  logic [7:0]       rd_byte,
    output logic [4:0]       rd_addr,
    output logic [2:0]       rd_bit,
    output logic             rd_en,
    output logic             ser_out,
    output logic [4:0]       chan_idx,
    output logic [2:0]       bit_idx,
    output logic             fbit_slot,
    output logic             chan_clk
    ,output logic            mf_pulse
);
    localparam int FLEN_W = POS_W + 1;
    localparam int NDEC   = 2;

    typedef struct packed {
        logic             fs;
        logic [POS_W-1:0] pos;
    } tim_st_t;

    tim_st_t q, d;
    logic              rise, frame_end;
    logic [FLEN_W-1:0] flen, ahead, dsum, dwrap;
    logic [POS_W-1:0]  dec_pos  [NDEC];
    slot_t             dec_slot [NDEC];

    always_comb begin
        d         = q;
        flen      = sys_e1 ? FLEN_W'(E1_FRAME) : FLEN_W'(T1_FRAME);
        rise      = fsync & ~q.fs;
        frame_end = ({1'b0, q.pos} >= flen - FLEN_W'(1)) & ~rise;
        d.fs      = fsync;
        if (rise || frame_end) d.pos = '0;
        else                   d.pos = q.pos + POS_W'(1);
        ahead = par_mode ? FLEN_W'(LOOKAHEAD) : '0;
        dsum  = {1'b0, q.pos} + ahead;
        dwrap = (dsum >= flen) ? dsum - flen : dsum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dec_pos[0] = q.pos;
    assign dec_pos[1] = dwrap[POS_W-1:0];

    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        sft_slot_decode u_dec (
            .pos    (dec_pos[g]),
            .sys_e1 (sys_e1),
            .slot   (dec_slot[g])
        );
    end

    sft_mf_ctrl #(
        .MF_FRAMES (MF_FRAMES),
        .MF_HOLD   (MF_HOLD)
    ) u_mf (
        .clk       (clk),
        .rst_n     (rst_n),
        .resync    (rise),
        .frame_end (frame_end),
        .slip_rep  (slip_rep),
        .slip_del  (slip_del),
        .mf_pulse  (mf_pulse)
    );

    assign chan_idx  = dec_slot[0].chan;
    assign bit_idx   = dec_slot[0].bitn;
    assign fbit_slot = dec_slot[0].fslot;
    assign chan_clk  = ~dec_slot[0].fslot & (dec_slot[0].bitn < BIT_W'(BYTE_BITS / 2));

    assign rd_addr = dec_slot[1].chan;
    assign rd_bit  = dec_slot[1].bitn;
    assign rd_en   = ~dec_slot[1].fslot;
    assign ser_out = rd_en ? rd_byte[BIT_W'(BYTE_BITS - 1) - rd_bit] : (rx_e1 | rx_fbit);
endmodule

// File: rtl/sft_checker.sv
`timescale 1ns/1ps
module sft_checker #(
    parameter int MF_HOLD = 65
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_e1,
    input logic       rx_e1,
    input logic       fsync,
    input logic [4:0] rd_addr,
    input logic       rd_en,
    input logic       ser_out,
    input logic [4:0] chan_idx,
    input logic [2:0] bit_idx,
    input logic       fbit_slot,
    input logic       chan_clk,
    input logic       mf_pulse
);
    localparam int CW = $clog2(MF_HOLD + 1);
    logic          fs_c;
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_c   <= 1'b0;
            hi_cnt <= '0;
        end else begin
            fs_c <= fsync;
            if (fsync && !fs_c)                          hi_cnt <= '0;
            else if (!mf_pulse)                          hi_cnt <= '0;
            else if (hi_cnt < CW'(MF_HOLD))              hi_cnt <= hi_cnt + CW'(1);
        end
    end

    a_r3_sync_aligns: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !fs_c) |=> (chan_idx == 5'd0 && bit_idx == 3'd0 && fbit_slot == !sys_e1));

    a_r6_no_chclk_in_fslot: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_slot |-> !chan_clk);

    a_r8_fbit_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_e1 && rx_e1 && !rd_en) |-> ser_out);

    a_r9_t1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_e1 && rd_en) |-> (rd_addr < 5'd24));

    a_r10_mf_max_width: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse |-> (hi_cnt < CW'(MF_HOLD)));

    a_r10_mf_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mf_pulse) |-> ($past(hi_cnt) == CW'(MF_HOLD - 1)));

    a_r12_no_fslot_e1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_e1 |-> (!fbit_slot && rd_en));
endmodule

bind sys_frame_timer sft_checker #(.MF_HOLD(MF_HOLD)) u_chk (.*);

// File: tb/sim_sys_frame_timer.sv
`timescale 1ns/1ps
module sim_sys_frame_timer;
    localparam int MF = 12;
    localparam int T1L = 193;
    localparam int E1L = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sys_e1 = 0, rx_e1 = 0, par_mode = 0, fsync = 0;
    logic slip_rep = 0, slip_del = 0, rx_fbit = 0;
    logic [7:0] rd_byte;
    logic [4:0] rd_addr, chan_idx;
    logic [2:0] rd_bit, bit_idx;
    logic rd_en, ser_out, fbit_slot, chan_clk, mf_pulse;
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    sys_frame_timer u0 (.*);

    function automatic logic [7:0] pat(input logic [4:0] a);
        return (8'({3'b0, a}) * 8'd29) + 8'h4B;
    endfunction

    always_comb rd_byte = pat(rd_addr);

    function automatic logic exp_ser(input int p);
        int flen = sys_e1 ? E1L : T1L;
        int dp   = par_mode ? (p + 8) % flen : p;
        int k;
        logic [7:0] b;
        if (!sys_e1 && dp == 0) return rx_e1 | rx_fbit;
        k = sys_e1 ? dp : dp - 1;
        b = pat(5'(k / 8));
        return b[7 - (k % 8)];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync();
        @(negedge clk) fsync = 1'b1;
        @(negedge clk) fsync = 1'b0;
    endtask

    // sweeps one frame starting at position 0, comparing data and timing
    task automatic sweep(input string tag, input int flen);
        int bad_ser = 0, bad_clk = 0, max_addr = 0;
        for (int p = 0; p < flen; p++) begin
            int bp = sys_e1 ? p % 8 : (p == 0 ? 0 : (p - 1) % 8);
            logic eclk = (sys_e1 || p != 0) && bp < 4;
            if (ser_out !== exp_ser(p)) bad_ser++;
            if (chan_clk !== eclk) bad_clk++;
            if (rd_en && int'(rd_addr) > max_addr) max_addr = int'(rd_addr);
            adv(1);
        end
        chk({tag, " R4/R5 data"}, bad_ser, 0);
        chk({tag, " R6 chan_clk"}, bad_clk, 0);
        chk({tag, " R9 max rd_addr"}, max_addr, sys_e1 ? 31 : 23);
    endtask

    task automatic t_reset();
        chk("R1 fbit_slot", fbit_slot, 1);
        chk("R1 chan_idx", chan_idx, 0);
        chk("R1 mf_pulse", mf_pulse, 0);
    endtask

    task automatic t_t1_serial();
        sys_e1 = 0; rx_e1 = 0; par_mode = 0; rx_fbit = 0;
        sync();
        chk("R7 fslot carries rx_fbit=0", ser_out, 0);
        chk("R12 rd_en low in fslot", rd_en, 0);
        sweep("T1 serial", T1L);
        chk("R2 T1 wrap fbit_slot", fbit_slot, 1);
        chk("R3 flywheel chan_idx", chan_idx, 0);
        rx_fbit = 1;
        adv(T1L);
        chk("R7 fslot carries rx_fbit=1", ser_out, 1);
        adv(1);
        chk("R4 first data bit msb", ser_out, pat(5'd0) >> 7);
        chk("R2 pos1 channel 0 bit 0", {chan_idx, bit_idx}, 8'd0);
    endtask

    task automatic t_e1rx_t1sys();
        sys_e1 = 0; rx_e1 = 1; par_mode = 0; rx_fbit = 0;
        sync();
        chk("R8 fslot forced one", ser_out, 1);
        sweep("E1rx T1sys R9", T1L);
    endtask

    task automatic t_e1sys();
        sys_e1 = 1; rx_e1 = 1; par_mode = 0;
        sync();
        chk("R12 e1 no fbit_slot", fbit_slot, 0);
        chk("R2 e1 pos0 rd_en", rd_en, 1);
        sweep("E1 serial", E1L);
        chk("R2 e1 wraps after 256", {chan_idx, bit_idx}, 8'd0);
        adv(E1L - 1);
        chk("R2 e1 last chan", chan_idx, 31);
        chk("R2 e1 last bit", bit_idx, 7);
    endtask

    task automatic t_parallel();
        sys_e1 = 0; rx_e1 = 0; par_mode = 1; rx_fbit = 1;
        sync();
        chk("R5 timing stays current", fbit_slot, 1);
        chk("R5 data leads by 8", {rd_addr, rd_bit}, {5'd0, 3'd7});
        sweep("T1 parallel", T1L);
        adv(T1L - 8);
        chk("R5 lookahead reaches fslot", rd_en, 0);
        chk("R5 T1 wrap data fbit", ser_out, 1);
        sys_e1 = 1;
        sync();
        sweep("E1 parallel", E1L);
        par_mode = 0;
    endtask

    task automatic t_realign();
        sys_e1 = 0; rx_e1 = 0;
        sync();
        adv(50);
        chk("R3 mid-frame not aligned", fbit_slot, 0);
        sync();
        chk("R3 realign fbit_slot", fbit_slot, 1);
        adv(1);
        chk("R3 realign next pos", {chan_idx, bit_idx}, 8'd0);
    endtask

    task automatic t_mf();
        sys_e1 = 0;
        sync();
        chk("R10 mf high at start", mf_pulse, 1);
        adv(64);
        chk("R10 mf high at 64", mf_pulse, 1);
        adv(1);
        chk("R10 mf low at 65", mf_pulse, 0);
        adv(MF * T1L - 1 - 65);
        chk("R10 mf low before boundary", mf_pulse, 0);
        adv(1);
        chk("R10 mf high at next multiframe", mf_pulse, 1);
    endtask

    task automatic t_slip(input logic rep);
        int t;
        sync();
        adv(10);
        if (rep) slip_rep = 1'b1; else slip_del = 1'b1;
        adv(1);
        slip_rep = 1'b0; slip_del = 1'b0;
        t = 11;
        if (rep) begin
            adv(MF * T1L - t);
            chk("R11 rep: no boundary at nominal", mf_pulse, 0);
            adv(T1L);
            chk("R11 rep: boundary one frame late", mf_pulse, 1);
        end else begin
            adv((MF - 1) * T1L - 1 - t);
            chk("R11 del: low before early boundary", mf_pulse, 0);
            adv(1);
            chk("R11 del: boundary one frame early", mf_pulse, 1);
        end
    endtask

    initial begin
        adv(3);
        rst_n = 1'b1;
        t_reset();
        t_t1_serial();
        t_e1rx_t1sys();
        t_e1sys();
        t_parallel();
        t_realign();
        t_mf();
        t_slip(1'b1);
        t_slip(1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule